// File: doc/BRIEF.md
# Fast A20 Gate Command Sequencer

This block sits on the host side of a keyboard-controller style 8-bit port. It watches host writes and recognises the short command, data and terminator exchange that switches the A20 address gate. It then drives the gate level directly, so the internal CPU never has to service these writes. Writes that are not part of a valid exchange are handed on to the CPU. For each such write the block raises a one-cycle pulse that sets the input-buffer-full flag.

A write carries an address bit that separates a command (bit at 1) from data (bit at 0). The arm command 0xD1 opens an exchange. The next data byte sets the gate from its bit 1. Then either 0xFF closes the exchange quietly, or any other command closes it in shortened form and still reaches the CPU. An exchange can be cancelled, retriggered, or chained into the next one.

A pin-shutdown input can float the gate output and block all host writes, but only when both enable inputs allow it. Each write is taken on the rising edge of the write strobe while chip select is low. Its result appears on the outputs one clock later.

Top module: `fast_gate_seq`

## Requirements
- R1: After reset, `gate_out` is 1, `gate_oe` is 1, `ibf_set` is 0, and no exchange is armed.
- R2: A command write of 0xD1 arms the exchange, leaves `gate_out` unchanged, and produces no `ibf_set` pulse.
- R3: A data write (`host_cmd`=0) while armed copies data bit 1 to `gate_out`, produces no `ibf_set` pulse, and marks the data as loaded.
- R4: A command of 0xFF after the loaded data closes the exchange. `gate_out` holds and there is no `ibf_set` pulse.
- R5: A command other than 0xFF or 0xD1 after the loaded data closes the exchange in shortened form. `gate_out` holds, `ibf_set` pulses, and the block returns to idle.
- R6: While armed with no data yet, any command other than 0xD1 (0xFF included) cancels the exchange. `gate_out` is unchanged, `ibf_set` pulses, and the block returns to idle.
- R7: A further 0xD1 while armed keeps the exchange armed, with no `ibf_set` pulse and no change to `gate_out`.
- R8: A 0xD1 right after the loaded data re-arms the exchange, so the next data write again sets `gate_out` from bit 1.
- R9: A data write while idle, or a second data write after the loaded data, leaves `gate_out` unchanged, pulses `ibf_set`, and leaves the block idle.
- R10: When `hif_en`=1, `shdn_en`=1 and `shdn_n`=0, `gate_oe` is 0 and every host write is ignored. No pulse is produced and the exchange state does not change.
- R11: If `hif_en` or `shdn_en` is 0, `shdn_n` has no effect: `gate_oe` stays 1 and writes are decoded.
- R12: A write counts only on a rising edge of `host_wr_n` while `host_cs_n` is 0. Its effect shows on the outputs in the following clock cycle. `ibf_set` is high for exactly one cycle per forwarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cmd | input | 1 | Address bit: 1 for command, 0 for data |
| host_data | input | DW | Write data byte |
| hif_en | input | 1 | Host interface enable |
| shdn_en | input | 1 | Allows the shutdown pin to act |
| shdn_n | input | 1 | Shutdown pin, active low |
| gate_out | output | 1 | A20 gate level |
| gate_oe | output | 1 | Output enable for the gate pin; 0 means high impedance |
| ibf_set | output | 1 | One-cycle pulse that sets the input-buffer-full flag |

## Verification
The bench builds the block with its default parameters: 8-bit data, 0xD1 as the arm code, 0xFF as the end code, and bit 1 as the gate bit. Data bytes are chosen so that bit 1 differs from every other bit, which exposes a wrong bit select. The default codes let the bench drive every transition of the three-state exchange: cancel from armed, retrigger, chaining, and a second data write. Both enable inputs are toggled on their own, so each of the three shutdown qualifiers is checked separately.

// File: rtl/fast_gate_seq.sv
module fast_gate_seq #(
  parameter int DW = 8,
  parameter logic [DW-1:0] ARM_CMD = 8'hD1,
  parameter logic [DW-1:0] END_CMD = 8'hFF,
  parameter int GATE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_wr_n,
  input  logic          host_cmd,
  input  logic [DW-1:0] host_data,
  input  logic          hif_en,
  input  logic          shdn_en,
  input  logic          shdn_n,
  output logic          gate_out,
  output logic          gate_oe,
  output logic          ibf_set
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_LOADED} seq_t;

  seq_t st, st_n;
  logic gate_n, ibf_n, wr_q;

  logic shut, cs_i, wr_i, cmd_i, strobe, is_arm, is_end;

  assign shut   = hif_en & shdn_en & ~shdn_n;
  assign cs_i   = shut | host_cs_n;
  assign wr_i   = shut | host_wr_n;
  assign cmd_i  = shut | host_cmd;
  assign strobe = ~wr_q & wr_i & ~cs_i;
  assign is_arm = cmd_i && (host_data == ARM_CMD);
  assign is_end = cmd_i && (host_data == END_CMD);
  assign gate_oe = ~shut;

  always_comb begin
    st_n   = st;
    gate_n = gate_out;
    ibf_n  = 1'b0;
    if (strobe) begin
      if (is_arm) begin
        st_n = S_ARMED;
      end else if (is_end && st == S_LOADED) begin
        st_n = S_IDLE;
      end else if (!cmd_i && st == S_ARMED) begin
        gate_n = host_data[GATE_BIT];
        st_n   = S_LOADED;
      end else begin
        ibf_n = 1'b1;
        st_n  = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      gate_out <= 1'b1;
      ibf_set  <= 1'b0;
      wr_q     <= 1'b1;
    end else begin
      st       <= st_n;
      gate_out <= gate_n;
      ibf_set  <= ibf_n;
      wr_q     <= wr_i;
    end
  end

  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_set |=> !ibf_set);

  assert_gate_quiet_on_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_out) |-> !ibf_set);

  assert_arm_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && is_arm) |=> (st == S_ARMED && !ibf_set && $stable(gate_out)));

  assert_shutdown_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hif_en && shdn_en && !shdn_n) |=> (!ibf_set && $stable(st)));

  assert_gate_only_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_out) |-> $past(st) == S_ARMED);

  assert_end_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && is_end && st == S_LOADED) |=> (st == S_IDLE && !ibf_set));

endmodule

// File: tb/fast_gate_seq_bench.sv
module fast_gate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_cs_n = 1'b1, host_wr_n = 1'b1, host_cmd = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic hif_en = 1'b1, shdn_en = 1'b0, shdn_n = 1'b1;
  logic gate_out, gate_oe, ibf_set;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  typedef struct { bit gate; bit ibf; bit oe; string tag; } exp_t;
  exp_t q[$];

  int m_st = 0;      // 0 idle, 1 armed, 2 loaded
  bit m_gate = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_gate_seq u_fast_gate_seq (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
    .host_cmd(host_cmd), .host_data(host_data), .hif_en(hif_en),
    .shdn_en(shdn_en), .shdn_n(shdn_n), .gate_out(gate_out),
    .gate_oe(gate_oe), .ibf_set(ibf_set));

  function automatic bit model_shut();
    return hif_en && shdn_en && !shdn_n;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic host_write(input bit cs_n, input bit cmd, input logic [7:0] d, input string tag);
    exp_t e;
    bit ibf = 0;
    @(negedge clk);
    host_cs_n = cs_n; host_cmd = cmd; host_data = d; host_wr_n = 1'b0;
    @(negedge clk);
    host_wr_n = 1'b1;
    @(posedge clk);
    if (!cs_n && !model_shut()) begin
      if (cmd && d == 8'hD1) m_st = 1;
      else if (cmd && d == 8'hFF && m_st == 2) m_st = 0;
      else if (!cmd && m_st == 1) begin m_gate = d[1]; m_st = 2; end
      else begin ibf = 1; m_st = 0; end
    end
    e.gate = m_gate; e.ibf = ibf; e.oe = !model_shut(); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_oe(input bit exp, input string tag);
    @(negedge clk); #1;
    check(gate_oe === exp, tag, $sformatf("oe=%b", gate_oe), $sformatf("oe=%b", exp));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(gate_out === e.gate && ibf_set === e.ibf && gate_oe === e.oe, e.tag,
              $sformatf("gate=%b ibf=%b oe=%b", gate_out, ibf_set, gate_oe),
              $sformatf("gate=%b ibf=%b oe=%b", e.gate, e.ibf, e.oe));
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    check(gate_out === 1'b1 && gate_oe === 1'b1 && ibf_set === 1'b0, "R1 reset",
          $sformatf("gate=%b oe=%b ibf=%b", gate_out, gate_oe, ibf_set), "gate=1 oe=1 ibf=0");
    @(negedge clk); rst_n = 1'b1;
    // R1: idle after reset -> data goes to CPU
    host_write(0, 0, 8'hFD, "R1 idle data forwarded");
    // R2 R3 R4 full sequence
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 0, 8'hFD, "R3 data bit1=0");
    host_write(0, 1, 8'hFF, "R4 end");
    host_write(0, 0, 8'h02, "R9 data while idle");
    // R5 shortened form
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 0, 8'h02, "R3 data bit1=1");
    host_write(0, 1, 8'hAB, "R5 shortened end");
    host_write(0, 0, 8'hFD, "R5 idle after shortened end");
    // R6 cancel
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 1, 8'h55, "R6 cancel by other cmd");
    host_write(0, 0, 8'hFD, "R6 idle after cancel");
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 1, 8'hFF, "R6 cancel by end code");
    // R7 retrigger
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 1, 8'hD1, "R7 retrigger");
    host_write(0, 0, 8'hFD, "R7 data after retrigger");
    // R8 chained
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 0, 8'h02, "R3 data bit1=1");
    host_write(0, 1, 8'hD1, "R8 rearm after data");
    host_write(0, 0, 8'hFD, "R8 second data");
    host_write(0, 1, 8'hFF, "R4 end");
    // R9 second data
    host_write(0, 1, 8'hD1, "R2 arm");
    host_write(0, 0, 8'h02, "R3 data bit1=1");
    host_write(0, 0, 8'hFD, "R9 second data forwarded");
    // R12 chip select high
    host_write(1, 1, 8'hD1, "R12 write without cs ignored");
    host_write(0, 0, 8'hFD, "R12 still idle");
    // R10 shutdown
    shdn_en = 1'b1; shdn_n = 1'b0;
    check_oe(1'b0, "R10 oe low in shutdown");
    host_write(0, 1, 8'hD1, "R10 write ignored in shutdown");
    host_write(0, 0, 8'hFD, "R10 data ignored in shutdown");
    @(negedge clk); shdn_n = 1'b1;
    host_write(0, 0, 8'hFD, "R10 state unchanged by shutdown writes");
    // R11 enables
    @(negedge clk); shdn_en = 1'b0; shdn_n = 1'b0;
    check_oe(1'b1, "R11 oe with shdn_en=0");
    host_write(0, 1, 8'hD1, "R11 arm with shdn_en=0");
    host_write(0, 0, 8'hFD, "R11 data with shdn_en=0");
    @(negedge clk); shdn_en = 1'b1; hif_en = 1'b0;
    check_oe(1'b1, "R11 oe with hif_en=0");
    host_write(0, 1, 8'hD1, "R11 arm with hif_en=0");
    host_write(0, 0, 8'h02, "R11 data with hif_en=0");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R12 scoreboard drained", $sformatf("%0d", q.size()), "0");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule